// File: doc/BRIEF.md
# Multi-Mode Digital Pattern Generator

This block produces known digital sequences on a wide parallel bus, together with a separate strobe pin, so that a logic analyser can be set up and practised on signals whose content is known in advance. It has three synthetic patterns (a flashing bus, a binary count and a single rotating bit). It also has a playback mode that presents words preloaded into an internal memory, one word per strobe, in address order.

A four-bit speed code sets the strobe rate. Code 0 gives one strobe every two system clocks, and each higher code doubles that period. A sequence is the run of words from index 0 up to a programmable last index. Repetition is optional. A stop request is honoured only where a sequence ends. The output word changes only while the strobe falls and is held across its rising edge, so the analyser samples on the rising edge. The memory and the last-index register are written through a simple address/data port while the generator is idle.

Top module: `pgen_top`

## Requirements
- R1: After reset `pat_out` is all zeros, `strobe_out` is low, the generator is idle and the last index equals DEPTH-1.
- R2: A `start` pulse while idle presents the first word with the strobe low. For an effective code c, the strobe rises 2^c clocks later and then toggles every 2^c clocks. Codes above 9 behave as 9. Mode, speed and repeat are captured at start.
- R3: While running, `pat_out` changes only on the clock where the strobe falls (or at start), and it is unchanged on the clock where the strobe rises.
- R4: Mode 0 (flash) presents all ones first and inverts the whole bus on each strobe fall.
- R5: Mode 1 (count) presents zero first and adds one on each strobe fall, wrapping from all ones to zero.
- R6: Mode 2 (rotate) presents a one in bit 0 first and rotates left by one on each strobe fall, with the top bit moving back to bit 0.
- R7: Mode 3 (playback) presents memory words 0, 1, ... up to the last index, one per strobe. Raising `wr_en` writes `wr_data` at `wr_addr`. Raising `last_we` loads `wr_addr` into the last-index register.
- R8: Every mode counts words 0 up to the last index as one sequence. Without repeat, the generator goes idle at the strobe fall that ends the last word, holding that word with the strobe low. With repeat, playback restarts at word 0, and the synthetic patterns carry on from their current value.
- R9: A `stop` pulse while running takes effect at the next end of a sequence, where the generator goes idle as in R8. A `stop` pulse while idle has no effect.
- R10: While running, `wr_en`, `last_we` and `start` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence when idle |
| stop | input | 1 | Request idle at the next sequence end |
| mode | input | 2 | 0 flash, 1 count, 2 rotate, 3 playback |
| speed | input | 4 | Rate code, 0 fastest, 9 slowest |
| repeat_en | input | 1 | Run sequences back to back |
| wr_en | input | 1 | Write one memory word (idle only) |
| last_we | input | 1 | Load last index from wr_addr (idle only) |
| wr_addr | input | AW | Memory write address / last index value |
| wr_data | input | WIDTH | Memory write data |
| pat_out | output | WIDTH | Pattern bus |
| strobe_out | output | 1 | Strobe for the analyser, sampled on its rising edge |

## Verification
The bench builds the block with WIDTH=8 and DEPTH=16. With an 8-bit bus the count wrap from all ones to zero comes after 256 strobes, and the bit 7 to bit 0 rotation appears within a ten-word sequence. Both fit in a few thousand clocks. The 16-word memory lets sequence ends, repeat restarts and writes rejected during a run all happen several times in one run. An out-of-range speed code is also run, so that the measured strobe period shows the clamp at code 9.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [1:0] {
    PM_FLASH = 2'd0,
    PM_COUNT = 2'd1,
    PM_SHIFT = 2'd2,
    PM_PLAY  = 2'd3
  } pg_mode_e;

  localparam int unsigned CODE_W   = 4;
  localparam int unsigned MAX_CODE = 9;

  // clamp a requested speed code into the supported range
  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
    return (c > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : c;
  endfunction
endpackage

// File: rtl/pgen_rate.sv
module pgen_rate
  import pgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned CNT_W = MAX_CODE + 1;

  // half period in clocks minus one: 2^code - 1
  function automatic logic [CNT_W-1:0] reload_of(input logic [CODE_W-1:0] c);
    return (CNT_W'(1) << c) - CNT_W'(1);
  endfunction

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  reload_q;

  assign reload_q = reload_of(code_q);
  assign tick     = run && (cnt == '0) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt    <= '0;
    end else if (load) begin
      code_q <= clamp_code(code);
      cnt    <= reload_of(clamp_code(code));
    end else if (run) begin
      cnt <= (cnt == '0) ? reload_q : cnt - CNT_W'(1);
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= reload_q));
endmodule

// File: rtl/pgen_store.sv
module pgen_store #(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pgen_seq.sv
module pgen_seq
  import pgen_pkg::*;
#(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [1:0]       mode,
  input  logic             repeat_en,
  input  logic             tick,
  input  logic [AW-1:0]    last_idx,
  input  logic [WIDTH-1:0] rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic             running,
  output logic             start_ev,
  output logic [WIDTH-1:0] pat,
  output logic             strobe
);
  function automatic logic [WIDTH-1:0] seed_word(input pg_mode_e m, input logic [WIDTH-1:0] mw);
    case (m)
      PM_FLASH: return '1;
      PM_COUNT: return '0;
      PM_SHIFT: return WIDTH'(1);
      default:  return mw;
    endcase
  endfunction

  function automatic logic [WIDTH-1:0] step_word(input pg_mode_e m, input logic [WIDTH-1:0] cur,
                                                 input logic [WIDTH-1:0] mw);
    case (m)
      PM_FLASH: return ~cur;
      PM_COUNT: return cur + WIDTH'(1);
      PM_SHIFT: return {cur[WIDTH-2:0], cur[WIDTH-1]};
      default:  return mw;
    endcase
  endfunction

  pg_mode_e      mode_q;
  logic          rep_q;
  logic          pend_q;
  logic [AW-1:0] idx;
  logic [AW-1:0] idx_next;

  // named events for the assertions
  logic at_last, rise_ev, fall_ev, done_ev;

  assign start_ev = start && !running;
  assign at_last  = (idx == last_idx);
  assign idx_next = at_last ? '0 : idx + AW'(1);
  assign rise_ev  = running && tick && !strobe;
  assign fall_ev  = running && tick && strobe;
  assign done_ev  = fall_ev && at_last && (!rep_q || pend_q);
  assign rd_addr  = running ? idx_next : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      strobe  <= 1'b0;
      pat     <= '0;
      idx     <= '0;
      pend_q  <= 1'b0;
      rep_q   <= 1'b0;
      mode_q  <= PM_FLASH;
    end else if (start_ev) begin
      running <= 1'b1;
      strobe  <= 1'b0;
      pat     <= seed_word(pg_mode_e'(mode), rd_data);
      idx     <= '0;
      pend_q  <= 1'b0;
      rep_q   <= repeat_en;
      mode_q  <= pg_mode_e'(mode);
    end else if (running) begin
      if (stop) pend_q <= 1'b1;
      if (rise_ev) strobe <= 1'b1;
      if (fall_ev) begin
        strobe <= 1'b0;
        if (done_ev) begin
          running <= 1'b0;
        end else begin
          idx <= idx_next;
          pat <= step_word(mode_q, pat, rd_data);
        end
      end
    end
  end

  // R2
  idle_strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !strobe);
  // R3
  rise_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $stable(pat));
  // R3
  data_change_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$fell(strobe)) |-> $stable(pat));
  // R4
  flash_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && $fell(strobe) && mode_q == PM_FLASH) |-> (pat == ~$past(pat)));
  // R6
  shift_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode_q == PM_SHIFT) |-> ($countones(pat) == 1));
  // R7
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (idx <= last_idx));
  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && !running) |-> ($stable(pat) && !strobe));
endmodule

// File: rtl/pgen_top.sv
module pgen_top
  import pgen_pkg::*;
#(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [1:0]       mode,
  input  logic [3:0]       speed,
  input  logic             repeat_en,
  input  logic             wr_en,
  input  logic             last_we,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] pat_out,
  output logic             strobe_out
);
  logic             running;
  logic             start_ev;
  logic             tick;
  logic [AW-1:0]    last_q;
  logic [AW-1:0]    rd_addr;
  logic [WIDTH-1:0] rd_data;
  logic             mem_we;

  assign mem_we = wr_en && !running;

  always_ff @(posedge clk) begin
    if (!rst_n)                    last_q <= AW'(DEPTH - 1);
    else if (last_we && !running)  last_q <= wr_addr;
  end

  pgen_rate u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_ev),
    .run   (running),
    .code  (speed),
    .tick  (tick)
  );

  pgen_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  pgen_seq #(.WIDTH(WIDTH), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .mode      (mode),
    .repeat_en (repeat_en),
    .tick      (tick),
    .last_idx  (last_q),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .running   (running),
    .start_ev  (start_ev),
    .pat       (pat_out),
    .strobe    (strobe_out)
  );

  // R10
  last_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running) |-> $stable(last_q));
endmodule

// File: tb/sim_pgen_top.sv
module sim_pgen_top;
  localparam int W = 8;
  localparam int D = 16;
  localparam int A = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, stop = 0, repeat_en = 0, wr_en = 0, last_we = 0;
  logic [1:0] mode = 0;
  logic [3:0] speed = 0;
  logic [A-1:0] wr_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] pat_out;
  logic strobe_out;

  always #4 clk = ~clk;

  pgen_top #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .mode(mode), .speed(speed),
    .repeat_en(repeat_en), .wr_en(wr_en), .last_we(last_we), .wr_addr(wr_addr),
    .wr_data(wr_data), .pat_out(pat_out), .strobe_out(strobe_out));

  int errors = 0, checks = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [W-1:0] m_mem [D];
  logic [W-1:0] m_word = 0;
  bit m_run = 0, m_strobe = 0, m_rep = 0, m_pend = 0;
  int m_mode = 0, m_half = 1, m_left = 0, m_k = 0, m_last = D - 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_strobe = 0; m_word = '0; m_last = D - 1; m_pend = 0;
    end else if (!m_run) begin
      if (start) begin
        m_run = 1; m_mode = mode; m_rep = repeat_en; m_pend = 0; m_k = 0; m_strobe = 0;
        m_half = 1 << ((speed > 9) ? 9 : speed);
        m_left = m_half;
        case (m_mode)
          0: m_word = '1;
          1: m_word = '0;
          2: m_word = 1;
          default: m_word = m_mem[0];
        endcase
      end
      if (wr_en) m_mem[wr_addr] = wr_data;
      if (last_we) m_last = wr_addr;
    end else begin
      m_left--;
      if (m_left == 0) begin
        m_left = m_half;
        if (!m_strobe) m_strobe = 1;
        else begin
          m_strobe = 0;
          if (m_k == m_last && (!m_rep || m_pend)) m_run = 0;
          else begin
            m_k = (m_k == m_last) ? 0 : m_k + 1;
            case (m_mode)
              0: m_word = ~m_word;
              1: m_word = m_word + 1;
              2: m_word = {m_word[W-2:0], m_word[W-1]};
              default: m_word = m_mem[m_k];
            endcase
          end
        end
      end
      if (stop) m_pend = 1;
    end
  end

  // per-clock comparison plus R3 edge check and R5 wrap detection
  logic [W-1:0] prev_pat = 0;
  bit prev_strobe = 0, saw_wrap = 0, comparing = 0;
  int rise_gap = 0, last_gap = 0;
  always @(negedge clk) begin
    if (comparing) begin
      check(pat_out === m_word, tag, 32'(pat_out), 32'(m_word));
      check(strobe_out === m_strobe, "R2", 32'(strobe_out), 32'(m_strobe));
      if (strobe_out && !prev_strobe) begin
        check(pat_out === prev_pat, "R3", 32'(pat_out), 32'(prev_pat));
        last_gap = rise_gap; rise_gap = 0;
      end
      if (m_run && m_mode == 1 && prev_pat == '1 && pat_out == '0) saw_wrap = 1;
    end
    rise_gap++;
    prev_pat = pat_out; prev_strobe = strobe_out;
  end

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start(input int md, input int sp, input bit rp);
    mode = 2'(md); speed = 4'(sp); repeat_en = rp; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic set_last(input int v);
    wr_addr = A'(v); last_we = 1; @(negedge clk); last_we = 0;
  endtask

  task automatic wait_idle;
    while (m_run) @(negedge clk);
    clocks(3);
  endtask

  task automatic main;
    clocks(3);
    // R1 reset state
    check(pat_out === '0, "R1", 32'(pat_out), 0);
    check(strobe_out === 1'b0, "R1", 32'(strobe_out), 0);
    rst_n = 1; @(negedge clk);
    comparing = 1;
    // R7 memory load
    tag = "R7";
    for (int i = 0; i < D; i++) begin
      wr_addr = A'(i); wr_data = W'(i * 37 + 11); wr_en = 1; @(negedge clk);
    end
    wr_en = 0;
    // R4 flash, R8 halt without repeat
    tag = "R4"; set_last(4);
    pulse_start(0, 0, 0); wait_idle(); clocks(10);
    check(pat_out === '1 && !strobe_out, "R8", 32'(pat_out), 32'hFF);
    // R5 count with repeat and wrap, R9 stop at boundary
    tag = "R5"; set_last(3);
    pulse_start(1, 0, 1); clocks(560);
    stop = 1; @(negedge clk); stop = 0;
    tag = "R9"; wait_idle();
    check(saw_wrap, "R5", 32'(saw_wrap), 1);
    check(((pat_out + 1) % 4) == 0, "R9", 32'(pat_out), 32'(pat_out | 3));
    // R6 rotate
    tag = "R6"; set_last(9);
    pulse_start(2, 1, 0); wait_idle();
    check(pat_out === 8'h02, "R6", 32'(pat_out), 32'h02);
    // R7 playback with repeat, R10 writes and start ignored while running
    set_last(5); tag = "R7";
    pulse_start(3, 2, 1); clocks(30);
    tag = "R10";
    wr_addr = 5; wr_data = 8'hEE; wr_en = 1; @(negedge clk); wr_en = 0;
    wr_addr = 1; last_we = 1; @(negedge clk); last_we = 0;
    mode = 0; start = 1; @(negedge clk); start = 0;
    clocks(60);
    stop = 1; @(negedge clk); stop = 0;
    wait_idle();
    check(pat_out === W'(5 * 37 + 11), "R10", 32'(pat_out), 32'(W'(5 * 37 + 11)));
    // R9 stop while idle has no effect
    tag = "R9"; set_last(1);
    stop = 1; @(negedge clk); stop = 0;
    pulse_start(0, 0, 1); clocks(12);
    check(m_run && strobe_out !== 1'bx, "R9", 32'(m_run), 1);
    stop = 1; @(negedge clk); stop = 0; wait_idle();
    // R2 clamp of out-of-range code: period 1024
    tag = "R2";
    pulse_start(0, 12, 0); wait_idle();
    check(last_gap == 1024, "R2", 32'(last_gap), 1024);
    // R2 code 0 period 2
    pulse_start(1, 0, 0); wait_idle();
    check(last_gap == 2, "R2", 32'(last_gap), 2);
  endtask

  initial begin
    fork
      main();
      begin
        clocks(150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule